// File: doc/BRIEF.md
# Prioritized Trap Controller with Conflict Reset

The block gathers fault requests from four sources (arithmetic error, address error, stack error and oscillator failure), holds each in a pending bit, and offers the CPU one trap at a time. The CPU sees the highest-priority trap, its priority level, whether it is hard or soft, and its vector address. The vector comes from either a primary table or an alternate table. When the CPU acknowledges the offered trap, that trap moves from pending to being processed. A completion pulse ends the processing, and the next pending trap is then offered.

Hard traps stall instruction execution until they are acknowledged. If a lower-priority hard trap arrives while a higher-priority trap is already held (pending or being processed), the block does not queue it. It treats the event as a conflict: it raises a one-cycle device reset request, clears its own trap state and sets a sticky cause flag. The flag survives that reset and is cleared only by power-on reset or by software writing zero to it.

Top module: `trap_ctrl`

## Requirements
- R1: After power-on reset (rst_n low), trap_valid, stall, reset_req and trapr_flag are all 0. A request bit that is high at a clock edge sets the matching pending bit, and trap_valid rises in the following cycle when no trap is being processed.
- R2: Request bit positions and trap_id codes are 0 = arithmetic, 1 = address, 2 = stack and 3 = oscillator. Among pending traps, the one with the highest code is offered, and the others stay pending.
- R3: trap_level equals 11 plus trap_id. trap_hard is 1 exactly when the level is 12 or higher.
- R4: With alt_sel = 0, vector is 0x000006 for oscillator, 0x000008 for address, 0x00000A for stack and 0x00000C for arithmetic. With alt_sel = 1, each of these values is increased by 0x80.
- R5: An ack while trap_valid is high clears the offered trap's pending bit and marks that trap as being processed. trap_valid stays 0 until completion.
- R6: A done pulse while a trap is being processed ends the processing. In the next cycle, the highest remaining pending trap is offered.
- R7: stall is 1 while any hard trap (codes 1 to 3) is pending and not yet acknowledged, and 0 otherwise.
- R8: Requests that arrive in the same cycle never cause a conflict. A request from the arithmetic source never causes a conflict.
- R9: A conflict occurs when a hard request arrives for a source that is not pending, while a trap with a higher code is pending or being processed. On a conflict, reset_req is 1 for exactly one cycle, starting in the cycle after the request, and all pending and processing state is cleared.
- R10: trapr_flag is set together with reset_req. It then stays set through any later activity until rst_n is asserted or a status write (sts_wr = 1) with sts_wdata = 0 occurs. A write with sts_wdata = 1 has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| trap_req | input | 4 | Trap requests, one bit per source |
| alt_sel | input | 1 | Selects the alternate vector table |
| ack | input | 1 | CPU accepts the offered trap |
| done | input | 1 | CPU has finished processing the trap |
| sts_wr | input | 1 | Write strobe for the sticky flag |
| sts_wdata | input | 1 | Write data for the sticky flag; writing 0 clears it |
| trap_valid | output | 1 | A trap is offered to the CPU |
| trap_id | output | 2 | Code of the offered trap |
| trap_level | output | 4 | Priority level of the offered trap |
| trap_hard | output | 1 | The offered trap is hard |
| vector | output | VEC_W | Vector address of the offered trap |
| stall | output | 1 | Hold execution until hard traps are acknowledged |
| reset_req | output | 1 | Device reset request caused by a conflict |
| trapr_flag | output | 1 | Sticky flag recording a conflict reset |

## Verification
The assertions assume that rst_n is applied at start-up. They also assume that nothing outside the block clears its state between a conflict and the following cycle, so the cycle after reset_req shows an idle controller. They do not assume any ordering of ack and done, because the block ignores ack when no trap is offered and ignores done when no trap is being processed. The stimulus drives every input on the falling edge as a single-cycle pulse and drains each request pattern completely before applying the next one, so a conflict arises only in the scenarios built to produce one.

// File: rtl/trapc_pkg.sv
package trapc_pkg;
   localparam int unsigned NSRC       = 4;
   localparam int unsigned IDW        = 2;
   localparam int unsigned BASE_LEVEL = 11;
   localparam int unsigned HARD_LEVEL = 12;

   typedef enum logic [IDW-1:0] {
      SRC_MATH  = 2'd0,
      SRC_ADDR  = 2'd1,
      SRC_STACK = 2'd2,
      SRC_OSC   = 2'd3
   } trap_src_e;

   // position of a source inside its vector table
   function automatic logic [IDW-1:0] table_slot(input logic [IDW-1:0] id);
      case (id)
         SRC_OSC:   table_slot = 2'd0;
         SRC_ADDR:  table_slot = 2'd1;
         SRC_STACK: table_slot = 2'd2;
         default:   table_slot = 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/trapc_prio.sv
module trapc_prio #(
   parameter int unsigned N = 4,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   logic [N-1:0] grant;

   for (genvar i = 0; i < N; i++) begin : g_grant
      if (i == N - 1) begin : g_top
         assign grant[i] = req_vec[i];
      end else begin : g_low
         assign grant[i] = req_vec[i] & ~(|req_vec[N-1:i+1]);
      end
   end

   assign any = |req_vec;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/trapc_vec.sv
module trapc_vec
   import trapc_pkg::*;
#(
   parameter int unsigned VEC_W      = 24,
   parameter logic [31:0] PRI_BASE   = 32'h0000_0004,
   parameter logic [31:0] ALT_BASE   = 32'h0000_0084,
   parameter int unsigned SLOT_BYTES = 2
) (
   input  logic [IDW-1:0]   id,
   input  logic             alt_sel,
   output logic [VEC_W-1:0] vector
);
   localparam logic [VEC_W-1:0] PRI_V = VEC_W'(PRI_BASE);
   localparam logic [VEC_W-1:0] ALT_V = VEC_W'(ALT_BASE);
   localparam logic [VEC_W-1:0] STEP  = VEC_W'(SLOT_BYTES);

   logic [VEC_W-1:0] slot_num;

   assign slot_num = VEC_W'(table_slot(id)) + VEC_W'(1);
   assign vector   = (alt_sel ? ALT_V : PRI_V) + STEP * slot_num;
endmodule

// File: rtl/trapc_conflict.sv
module trapc_conflict
   import trapc_pkg::*;
(
   input  logic [NSRC-1:0] trap_req,
   input  logic [NSRC-1:0] pending,
   input  logic            active_vld,
   input  logic [IDW-1:0]  active_id,
   output logic            conflict
);
   logic [NSRC-1:0] held;
   logic [NSRC-1:0] hit;

   always_comb begin
      held = pending;
      if (active_vld) held[active_id] = 1'b1;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if ((BASE_LEVEL + i) < HARD_LEVEL || i == NSRC - 1) begin : g_none
         assign hit[i] = 1'b0;
      end else begin : g_hard
         assign hit[i] = trap_req[i] & ~pending[i] & (|held[NSRC-1:i+1]);
      end
   end

   assign conflict = |hit;
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
   import trapc_pkg::*;
#(
   parameter int unsigned VEC_W      = 24,
   parameter logic [31:0] PRI_BASE   = 32'h0000_0004,
   parameter logic [31:0] ALT_BASE   = 32'h0000_0084,
   parameter int unsigned SLOT_BYTES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       trap_req,
   input  logic             alt_sel,
   input  logic             ack,
   input  logic             done,
   input  logic             sts_wr,
   input  logic             sts_wdata,
   output logic             trap_valid,
   output logic [1:0]       trap_id,
   output logic [3:0]       trap_level,
   output logic             trap_hard,
   output logic [VEC_W-1:0] vector,
   output logic             stall,
   output logic             reset_req,
   output logic             trapr_flag
);
   if (VEC_W < 8 || VEC_W > 32) begin : g_bad_vecw
      $error("trap_ctrl: VEC_W must lie in 8..32");
   end
   if (SLOT_BYTES < 1 || SLOT_BYTES > 8) begin : g_bad_slot
      $error("trap_ctrl: SLOT_BYTES must lie in 1..8");
   end
   if (PRI_BASE == ALT_BASE) begin : g_bad_base
      $error("trap_ctrl: the two vector tables must differ");
   end

   localparam logic [NSRC-1:0] HARD_MASK = NSRC'(((1 << NSRC) - 1) >> (HARD_LEVEL - BASE_LEVEL)) << (HARD_LEVEL - BASE_LEVEL);

   logic [NSRC-1:0] pending_q;
   logic            active_vld_q;
   logic [IDW-1:0]  active_id_q;
   logic            reset_req_q;
   logic            flag_q;
   logic            win_any;
   logic [IDW-1:0]  win_id;
   logic            conflict;
   logic            ack_fire;
   logic            done_fire;
   logic [NSRC-1:0] ack_clr;

   trapc_prio #(.N(NSRC)) u_prio (
      .req_vec (pending_q),
      .any     (win_any),
      .idx     (win_id)
   );

   trapc_vec #(
      .VEC_W      (VEC_W),
      .PRI_BASE   (PRI_BASE),
      .ALT_BASE   (ALT_BASE),
      .SLOT_BYTES (SLOT_BYTES)
   ) u_vec (
      .id      (win_id),
      .alt_sel (alt_sel),
      .vector  (vector)
   );

   trapc_conflict u_conf (
      .trap_req   (trap_req),
      .pending    (pending_q),
      .active_vld (active_vld_q),
      .active_id  (active_id_q),
      .conflict   (conflict)
   );

   assign trap_valid = win_any & ~active_vld_q;
   assign ack_fire   = ack & trap_valid;
   assign done_fire  = done & active_vld_q;

   always_comb begin
      ack_clr = '0;
      if (ack_fire) ack_clr[win_id] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q    <= '0;
         active_vld_q <= 1'b0;
         active_id_q  <= '0;
         reset_req_q  <= 1'b0;
      end else if (conflict) begin
         pending_q    <= '0;
         active_vld_q <= 1'b0;
         active_id_q  <= '0;
         reset_req_q  <= 1'b1;
      end else begin
         reset_req_q <= 1'b0;
         pending_q   <= (pending_q & ~ack_clr) | trap_req;
         if (ack_fire) begin
            active_vld_q <= 1'b1;
            active_id_q  <= win_id;
         end else if (done_fire) begin
            active_vld_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  flag_q <= 1'b0;
      else if (conflict)           flag_q <= 1'b1;
      else if (sts_wr && !sts_wdata) flag_q <= 1'b0;
   end

   assign trap_id    = win_id;
   assign trap_level = 4'(BASE_LEVEL) + 4'(win_id);
   assign trap_hard  = HARD_MASK[win_id];
   assign stall      = |(pending_q & HARD_MASK);
   assign reset_req  = reset_req_q;
   assign trapr_flag = flag_q;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
   parameter int unsigned VEC_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       trap_req,
   input logic             alt_sel,
   input logic             ack,
   input logic             done,
   input logic             sts_wr,
   input logic             sts_wdata,
   input logic             trap_valid,
   input logic [1:0]       trap_id,
   input logic [3:0]       trap_level,
   input logic             trap_hard,
   input logic [VEC_W-1:0] vector,
   input logic             stall,
   input logic             reset_req,
   input logic             trapr_flag
);
   assert_hard_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (trap_hard == (trap_level >= 4'd12)));

   assert_vec_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (vector[0] == 1'b0));

   assert_no_offer_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && ack) |=> !trap_valid);

   assert_stall_hard_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_hard) |-> stall);

   assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);

   assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> (!trap_valid && !stall));

   assert_flag_with_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> trapr_flag);

   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (trapr_flag && !(sts_wr && !sts_wdata)) |=> trapr_flag);
endmodule

bind trap_ctrl trap_ctrl_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/tb_trap_ctrl.sv
module tb_trap_ctrl;
   localparam int VEC_W = 24;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [3:0]       trap_req;
   logic             alt_sel, ack, done, sts_wr, sts_wdata;
   logic             trap_valid, trap_hard, stall, reset_req, trapr_flag;
   logic [1:0]       trap_id;
   logic [3:0]       trap_level;
   logic [VEC_W-1:0] vector;

   int checks = 0;
   int errors = 0;

   trap_ctrl #(.VEC_W(VEC_W)) dut (.*);

   always #5 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int top_bit(input logic [3:0] v);
      top_bit = 0;
      for (int i = 0; i < 4; i++) if (v[i]) top_bit = i;
   endfunction

   function automatic logic [31:0] exp_vec(input int id, input logic alt);
      int slot;
      case (id)
         3: slot = 0;
         1: slot = 1;
         2: slot = 2;
         default: slot = 3;
      endcase
      exp_vec = (alt ? 32'h84 : 32'h04) + 32'(2 * (slot + 1));
   endfunction

   task automatic pulse_req(input logic [3:0] r);
      @(negedge clk); trap_req = r;
      @(negedge clk); trap_req = '0;
   endtask

   task automatic pulse_ack;
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic pulse_done;
      @(negedge clk); done = 1'b1;
      @(negedge clk); done = 1'b0;
   endtask

   task automatic wr_flag(input logic d);
      @(negedge clk); sts_wr = 1'b1; sts_wdata = d;
      @(negedge clk); sts_wr = 1'b0; sts_wdata = 1'b0;
   endtask

   task automatic do_reset;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; trap_req = '0; alt_sel = 0; ack = 0; done = 0; sts_wr = 0; sts_wdata = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset trap_valid", 32'(trap_valid), 0);
      chk("R1 reset stall", 32'(stall), 0);
      chk("R1 reset reset_req", 32'(reset_req), 0);
      chk("R1 reset flag", 32'(trapr_flag), 0);

      // every request pattern, both tables, drained in priority order
      for (int p = 1; p < 16; p++) begin
         logic [3:0] rem;
         rem = 4'(p);
         alt_sel = p[0];
         pulse_req(rem);
         chk("R8 no conflict on same-cycle requests", 32'(reset_req), 0);
         chk("R7 stall after requests", 32'(stall), 32'(|rem[3:1]));
         while (rem != 0) begin
            int w;
            w = top_bit(rem);
            chk("R1 trap_valid", 32'(trap_valid), 1);
            chk("R2 winner", 32'(trap_id), 32'(w));
            chk("R3 level", 32'(trap_level), 32'(11 + w));
            chk("R3 hard", 32'(trap_hard), 32'(w >= 1));
            chk("R4 vector", 32'(vector), exp_vec(w, alt_sel));
            pulse_ack;
            rem[w] = 1'b0;
            chk("R5 no offer while processing", 32'(trap_valid), 0);
            chk("R7 stall after ack", 32'(stall), 32'(|rem[3:1]));
            pulse_done;
            chk("R6 offer after done", 32'(trap_valid), 32'(rem != 0));
         end
      end
      alt_sel = 0;

      // lower hard arrives while higher hard pending
      pulse_req(4'b1000);
      @(negedge clk); trap_req = 4'b0010;
      @(negedge clk); trap_req = '0;
      chk("R9 reset_req on pending conflict", 32'(reset_req), 1);
      chk("R9 state cleared", 32'(trap_valid), 0);
      chk("R9 stall cleared", 32'(stall), 0);
      chk("R10 flag set", 32'(trapr_flag), 1);
      @(negedge clk);
      chk("R9 reset_req single cycle", 32'(reset_req), 0);
      chk("R10 flag holds", 32'(trapr_flag), 1);
      wr_flag(1'b1);
      chk("R10 write 1 no effect", 32'(trapr_flag), 1);
      wr_flag(1'b0);
      chk("R10 write 0 clears", 32'(trapr_flag), 0);

      // lower hard arrives while higher one is being processed
      pulse_req(4'b0100);
      pulse_ack;
      @(negedge clk); trap_req = 4'b0010;
      @(negedge clk); trap_req = '0;
      chk("R9 reset_req on active conflict", 32'(reset_req), 1);
      chk("R10 flag set again", 32'(trapr_flag), 1);
      do_reset;
      chk("R10 power-on reset clears flag", 32'(trapr_flag), 0);
      chk("R1 reset idle", 32'(trap_valid), 0);

      // soft request under a hard one, then a higher hard request
      pulse_req(4'b0010);
      pulse_req(4'b0001);
      chk("R8 soft no conflict", 32'(reset_req), 0);
      chk("R2 hard keeps priority", 32'(trap_id), 1);
      pulse_req(4'b0100);
      chk("R9 higher arrival no conflict", 32'(reset_req), 0);
      chk("R2 higher wins", 32'(trap_id), 2);
      chk("R10 flag stays clear", 32'(trapr_flag), 0);
      for (int k = 0; k < 3; k++) begin
         pulse_ack;
         pulse_done;
      end
      chk("R6 drained", 32'(trap_valid), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule